// File: doc/BRIEF.md
# Two-Cycle 8x8 Multiply Unit

This unit performs the byte multiply operations of a small microcontroller core. It recognises three instruction words: unsigned times unsigned, signed times signed, and signed times unsigned. From the word it decodes the two source register indices. It presents them to the core's register file and takes the two operand bytes back in the same cycle. The 16-bit product is split into a low byte and a high byte. The core writes the low byte to register 0 and the high byte to register 1.

The core raises `start` with the instruction word and with the current status byte. The unit captures its operands on that edge and is busy for one cycle. It then raises `done` for one cycle. At that point the product and the new status byte are valid. The carry bit takes the value of product bit 15, and the zero bit shows an all-zero product. Every other status bit passes through unchanged. The results stay on the outputs until the next accepted operation.

Top module: `mul8_unit`

## Requirements
- R1: Unsigned form, word `1001 11rd dddd rrrr`: the first source index is {bit 8, bits 7:4} and the second is {bit 9, bits 3:0}, so any of registers 0 to 31 can be a source.
- R2: Signed form, word `0000 0010 dddd rrrr`: the first source index is 16 + bits 7:4 and the second is 16 + bits 3:0.
- R3: Mixed form, word `0000 0011 0ddd 0rrr`: the first source index is 16 + bits 6:4 and the second is 16 + bits 2:0. A word of the 0x03 group with bit 7 or bit 3 set is not a multiply.
- R4: In the unsigned form the product is the unsigned 16-bit product of the two bytes.
- R5: In the signed form both bytes are two's complement, and the product is the two's-complement 16-bit result.
- R6: In the mixed form the first byte is signed and the second is unsigned, and the product is the two's-complement 16-bit result.
- R7: When `done` is high, status bit 0 (carry) equals product bit 15.
- R8: When `done` is high, status bit 1 (zero) is 1 exactly when the product is 0.
- R9: Status bits 7:2 of the result equal the `statusIn` value sampled with the accepted `start`.
- R10: After `start` is accepted at edge k, `busy` is high after edge k and `done` is high for exactly one cycle after edge k+1.
- R11: The product and the status byte hold their values until the next accepted operation finishes.
- R12: A `start` with a word that is not one of the three multiplies is ignored: no `busy`, no `done`, and the outputs do not change.
- R13: A `start` while `busy` is high is ignored, and the running operation finishes with its own operands.
- R14: After reset, `busy`, `done`, the product and the status byte are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to run the operation held in `instr` |
| instr | input | 16 | Instruction word |
| srcAIdx | output | 5 | Index of the first source register, decoded from `instr` |
| srcBIdx | output | 5 | Index of the second source register, decoded from `instr` |
| srcAData | input | 8 | Contents of the first source register |
| srcBData | input | 8 | Contents of the second source register |
| statusIn | input | 8 | Current status byte |
| busy | output | 1 | Operation in progress (first cycle) |
| done | output | 1 | One-cycle pulse when the result is valid |
| prodLo | output | 8 | Product bits 7:0, destined for register 0 |
| prodHi | output | 8 | Product bits 15:8, destined for register 1 |
| statusOut | output | 8 | Status byte with carry and zero updated |

## Verification
The mixed-sign form is run over every pair of operand bytes. A design that sign-extends the second operand, or zero-extends the first, would give wrong high bytes for operands of 0x80 and above. The bench also issues the unsigned form with sources at registers 16 to 31 and at the same register for both sources. A decoder that ignores word bits 8 and 9 would read the wrong register. In the signed and mixed forms, one that drops the implied 16 offset would read a low register. Other cases target the sequencing. A second `start` during `busy` would corrupt the result if it were not ignored. Non-multiply words of the 0x03 group are applied and must be ignored. Carry is checked on products such as 40000 that have bit 15 set, because flagging an overflow instead of copying the bit would leave carry clear there.

// File: rtl/mul8_pkg.sv
package mul8_pkg;
  localparam int IDX_W = 5;

  typedef enum logic [1:0] {
    MODE_UU = 2'd0,
    MODE_SS = 2'd1,
    MODE_SU = 2'd2
  } mulMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch operands, mode and status
    logic commit;   // write product and flags
  } mulStrobe_t;
endpackage

// File: rtl/mul8_decode.sv
module mul8_decode
  import mul8_pkg::*;
(
  input  logic [15:0]      instr,
  output logic             opLegal,
  output mulMode_e         mode,
  output logic [IDX_W-1:0] idxA,
  output logic [IDX_W-1:0] idxB
);
  always_comb begin
    opLegal = 1'b0;
    mode    = MODE_UU;
    idxA    = '0;
    idxB    = '0;
    if (instr[15:10] == 6'b100111) begin
      opLegal = 1'b1;
      mode    = MODE_UU;
      idxA    = {instr[8], instr[7:4]};
      idxB    = {instr[9], instr[3:0]};
    end else if (instr[15:8] == 8'h02) begin
      opLegal = 1'b1;
      mode    = MODE_SS;
      idxA    = {1'b1, instr[7:4]};
      idxB    = {1'b1, instr[3:0]};
    end else if (instr[15:7] == 9'b0000_0011_0 && !instr[3]) begin
      opLegal = 1'b1;
      mode    = MODE_SU;
      idxA    = {2'b10, instr[6:4]};
      idxB    = {2'b10, instr[2:0]};
    end
  end
endmodule

// File: rtl/mul8_ctrl.sv
module mul8_ctrl
  import mul8_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       opLegal,
  output mulStrobe_t strobe,
  output logic       busy,
  output logic       done
);
  typedef enum logic {ST_IDLE, ST_CALC} ctrlState_e;
  ctrlState_e state, stateNext;

  always_comb begin
    strobe         = '0;
    stateNext      = state;
    strobe.capture = (state == ST_IDLE) && start && opLegal;
    strobe.commit  = (state == ST_CALC);
    if (strobe.capture) stateNext = ST_CALC;
    else if (strobe.commit) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobe.commit;
    end
  end

  assign busy = (state == ST_CALC);
endmodule

// File: rtl/mul8_datapath.sv
module mul8_datapath
  import mul8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STAT_W = 8,
  parameter int C_POS  = 0,
  parameter int Z_POS  = 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  mulStrobe_t            strobe,
  input  mulMode_e              mode,
  input  logic [DATA_W-1:0]     opA,
  input  logic [DATA_W-1:0]     opB,
  input  logic [STAT_W-1:0]     statusIn,
  output logic [2*DATA_W-1:0]   product,
  output logic [STAT_W-1:0]     statusOut
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int EXT_W  = DATA_W + 1;

  logic [DATA_W-1:0] aReg, bReg;
  logic [STAT_W-1:0] statKeep;
  mulMode_e          modeReg;

  logic signed [EXT_W-1:0]   aExt, bExt;
  logic signed [2*EXT_W-1:0] fullProd;
  logic [PROD_W-1:0]         prodNext;
  logic [STAT_W-1:0]         statNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg     <= '0;
      bReg     <= '0;
      statKeep <= '0;
      modeReg  <= MODE_UU;
    end else if (strobe.capture) begin
      aReg     <= opA;
      bReg     <= opB;
      statKeep <= statusIn;
      modeReg  <= mode;
    end
  end

  // one extra sign bit per operand covers all three signedness forms
  always_comb begin
    aExt     = {(modeReg != MODE_UU) & aReg[DATA_W-1], aReg};
    bExt     = {(modeReg == MODE_SS) & bReg[DATA_W-1], bReg};
    fullProd = aExt * bExt;
    prodNext = fullProd[PROD_W-1:0];
    statNext = statKeep;
    statNext[C_POS] = prodNext[PROD_W-1];
    statNext[Z_POS] = (prodNext == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      product   <= '0;
      statusOut <= '0;
    end else if (strobe.commit) begin
      product   <= prodNext;
      statusOut <= statNext;
    end
  end
endmodule

// File: rtl/mul8_unit.sv
module mul8_unit
  import mul8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STAT_W = 8,
  parameter int C_POS  = 0,
  parameter int Z_POS  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [15:0]       instr,
  output logic [IDX_W-1:0]  srcAIdx,
  output logic [IDX_W-1:0]  srcBIdx,
  input  logic [DATA_W-1:0] srcAData,
  input  logic [DATA_W-1:0] srcBData,
  input  logic [STAT_W-1:0] statusIn,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] prodLo,
  output logic [DATA_W-1:0] prodHi,
  output logic [STAT_W-1:0] statusOut
);
  logic              opLegal;
  mulMode_e          mode;
  mulStrobe_t        strobe;
  logic [2*DATA_W-1:0] product;

  mul8_decode decode_i (
    .instr(instr), .opLegal(opLegal), .mode(mode),
    .idxA(srcAIdx), .idxB(srcBIdx)
  );

  mul8_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .opLegal(opLegal),
    .strobe(strobe), .busy(busy), .done(done)
  );

  mul8_datapath #(
    .DATA_W(DATA_W), .STAT_W(STAT_W), .C_POS(C_POS), .Z_POS(Z_POS)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mode(mode),
    .opA(srcAData), .opB(srcBData), .statusIn(statusIn),
    .product(product), .statusOut(statusOut)
  );

  assign prodLo = product[DATA_W-1:0];
  assign prodHi = product[2*DATA_W-1:DATA_W];
endmodule

// File: rtl/mul8_unit_chk.sv
module mul8_unit_chk
  import mul8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STAT_W = 8,
  parameter int C_POS  = 0,
  parameter int Z_POS  = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              opLegal,
  input mulMode_e          mode,
  input logic [IDX_W-1:0]  srcAIdx,
  input logic [IDX_W-1:0]  srcBIdx,
  input logic [STAT_W-1:0] statusIn,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] prodLo,
  input logic [DATA_W-1:0] prodHi,
  input logic [STAT_W-1:0] statusOut
);
  localparam logic [STAT_W-1:0] KEEP_MASK =
    ~((STAT_W'(1) << C_POS) | (STAT_W'(1) << Z_POS));

  logic accept;
  assign accept = start && opLegal && !busy;

  p_ss_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opLegal && mode == MODE_SS) |-> (srcAIdx[4] && srcBIdx[4]));

  p_su_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opLegal && mode == MODE_SU) |-> (srcAIdx[4:3] == 2'b10 && srcBIdx[4:3] == 2'b10));

  p_carry_bit_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (statusOut[C_POS] == prodHi[DATA_W-1]));

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (statusOut[Z_POS] == ({prodHi, prodLo} == '0)));

  p_keep_bits_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((statusOut & KEEP_MASK) == ($past(statusIn, 2) & KEEP_MASK)));

  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (busy && !done));

  p_done_after_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (done && !busy));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_hold_result_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> ($stable({prodHi, prodLo}) && $stable(statusOut)));

  p_illegal_ignored_r12: assert property (@(posedge clk) disable iff (!rstN)
    (start && !opLegal && !busy) |=> !busy);
endmodule

bind mul8_unit mul8_unit_chk #(
  .DATA_W(DATA_W), .STAT_W(STAT_W), .C_POS(C_POS), .Z_POS(Z_POS)
) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .opLegal(opLegal), .mode(mode),
  .srcAIdx(srcAIdx), .srcBIdx(srcBIdx), .statusIn(statusIn),
  .busy(busy), .done(done), .prodLo(prodLo), .prodHi(prodHi),
  .statusOut(statusOut)
);

// File: tb/mul8_unit_tb_top.sv
module mul8_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [15:0] instr;
  logic [4:0]  srcAIdx, srcBIdx;
  logic [7:0]  srcAData, srcBData;
  logic [7:0]  statusIn;
  logic        busy, done;
  logic [7:0]  prodLo, prodHi, statusOut;
  logic [7:0]  rf [32];

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign srcAData = rf[srcAIdx];
  assign srcBData = rf[srcBIdx];

  mul8_unit dut_i (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr),
    .srcAIdx(srcAIdx), .srcBIdx(srcBIdx), .srcAData(srcAData), .srcBData(srcBData),
    .statusIn(statusIn), .busy(busy), .done(done),
    .prodLo(prodLo), .prodHi(prodHi), .statusOut(statusOut)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // mode 0 unsigned, 1 signed, 2 signed x unsigned
  function automatic logic [15:0] makeInstr(int mode, int d, int r);
    logic [4:0] dd = d[4:0];
    logic [4:0] rr = r[4:0];
    if (mode == 0) return {6'b100111, rr[4], dd[4], dd[3:0], rr[3:0]};
    if (mode == 1) return {8'h02, dd[3:0], rr[3:0]};
    return {9'b0000_0011_0, dd[2:0], 1'b0, rr[2:0]};
  endfunction

  function automatic logic [15:0] expProd(int mode, logic [7:0] a, logic [7:0] b);
    int sa, sb, p;
    sa = (mode != 0) ? int'($signed(a)) : int'(a);
    sb = (mode == 1) ? int'($signed(b)) : int'(b);
    p  = sa * sb;
    return p[15:0];
  endfunction

  function automatic logic [7:0] expStatus(logic [15:0] p, logic [7:0] st);
    return {st[7:2], (p == 16'h0), p[15]};
  endfunction

  // entered and left at a falling edge with busy low
  task automatic runOp(int mode, int d, int r, logic [7:0] a, logic [7:0] b, logic [7:0] st);
    string idxReq, prodReq;
    logic [15:0] ep;
    logic [7:0]  es;
    idxReq  = (mode == 0) ? "R1" : (mode == 1) ? "R2" : "R3";
    prodReq = (mode == 0) ? "R4" : (mode == 1) ? "R5" : "R6";
    rf[d] = a;
    rf[r] = b;
    if (d == r) a = b;
    ep = expProd(mode, a, b);
    es = expStatus(ep, st);
    instr    = makeInstr(mode, d, r);
    statusIn = st;
    start    = 1'b1;
    #1;
    check(srcAIdx == d[4:0] && srcBIdx == r[4:0], idxReq, "source indices",
          {srcAIdx, srcBIdx}, {d[4:0], r[4:0]});
    @(negedge clk);
    start    = 1'b0;
    statusIn = ~st;
    check(busy && !done, "R10", "busy phase", {busy, done}, 2'b10);
    @(negedge clk);
    check(done && !busy, "R10", "done phase", {busy, done}, 2'b01);
    check({prodHi, prodLo} == ep, prodReq, "product", {prodHi, prodLo}, ep);
    check(statusOut[0] == es[0], "R7", "carry", statusOut[0], es[0]);
    check(statusOut[1] == es[1], "R8", "zero", statusOut[1], es[1]);
    check(statusOut[7:2] == es[7:2], "R9", "kept status bits", statusOut[7:2], es[7:2]);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] heldP;
    logic [7:0]  heldS;
    void'($urandom(32'h1f2e3d4c));
    for (int i = 0; i < 32; i++) rf[i] = 8'h00;
    rstN = 1'b0; start = 1'b0; instr = 16'h0000; statusIn = 8'h00;
    repeat (3) @(negedge clk);
    check(!busy && !done && {prodHi, prodLo} == 16'h0 && statusOut == 8'h0, "R14",
          "reset state", {busy, done, prodHi, prodLo, statusOut}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed values
    runOp(0, 5, 6, 8'd100, 8'd5, 8'h00);      // 500: no flags
    runOp(0, 5, 6, 8'd200, 8'd200, 8'h00);    // 40000: carry
    runOp(0, 0, 1, 8'd0, 8'd9, 8'hfc);        // zero, upper bits kept
    runOp(1, 18, 19, 8'hfb, 8'd100, 8'h80);   // -5 * 100
    runOp(2, 16, 17, 8'hfb, 8'd200, 8'h40);   // -5 * 200 (second unsigned)
    runOp(0, 31, 17, 8'hff, 8'hff, 8'h00);    // high registers, both word bits
    runOp(0, 7, 7, 8'h9d, 8'h9d, 8'h55);      // same register twice
    runOp(1, 31, 16, 8'h80, 8'h80, 8'h00);    // -128 * -128
    runOp(2, 23, 16, 8'h80, 8'hff, 8'h00);    // -128 * 255

    // R11: results hold while idle, inputs wandering
    heldP = {prodHi, prodLo};
    heldS = statusOut;
    for (int i = 0; i < 3; i++) begin
      statusIn = 8'($urandom);
      rf[23]   = 8'($urandom);
      @(negedge clk);
    end
    check({prodHi, prodLo} == heldP && statusOut == heldS && !done, "R11",
          "hold while idle", {prodHi, prodLo}, heldP);

    // R12: non-multiply words ignored
    foreach (heldP[k]) begin end
    begin
      logic [15:0] illegal [3] = '{16'h0000, 16'h0388, 16'h0308};
      for (int i = 0; i < 3; i++) begin
        heldP    = {prodHi, prodLo};
        heldS    = statusOut;
        instr    = illegal[i];
        statusIn = 8'hff;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!busy, "R12", "no busy on illegal word", busy, 0);
        @(negedge clk);
        check(!done && {prodHi, prodLo} == heldP && statusOut == heldS, "R12",
              "outputs untouched", {done, prodHi, prodLo}, {1'b0, heldP});
      end
    end

    // R13: start while busy ignored
    rf[20] = 8'd12; rf[21] = 8'd11;
    instr = makeInstr(0, 20, 21); statusIn = 8'h00; start = 1'b1;
    @(negedge clk);
    rf[20] = 8'd250; rf[21] = 8'd250;
    instr = makeInstr(0, 20, 21); statusIn = 8'hfc;
    @(negedge clk);
    start = 1'b0;
    check(done && {prodHi, prodLo} == 16'd132 && statusOut == 8'h00, "R13",
          "second start during busy", {prodHi, prodLo}, 132);
    @(negedge clk);
    check(!done && !busy, "R13", "no extra operation", {busy, done}, 0);

    // signed x unsigned over every operand pair
    for (int i = 0; i < 65536; i++) begin
      int d, r;
      d = 16 + $urandom_range(0, 7);
      r = 16 + ((d - 16 + 1 + $urandom_range(0, 6)) % 8);
      runOp(2, d, r, i[7:0], i[15:8], 8'($urandom));
    end

    // random unsigned and signed forms
    for (int i = 0; i < 3000; i++) begin
      int d, r;
      d = $urandom_range(0, 31);
      r = $urandom_range(0, 31);
      runOp(0, d, r, 8'($urandom), 8'($urandom), 8'($urandom));
    end
    for (int i = 0; i < 3000; i++) begin
      int d, r;
      d = 16 + $urandom_range(0, 15);
      r = 16 + $urandom_range(0, 15);
      runOp(1, d, r, 8'($urandom), 8'($urandom), 8'($urandom));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule